// File: doc/BRIEF.md
# Power Management Clock Controller

This block produces the machine-cycle enable that paces a processor core. The enable is derived from one of two oscillators. One is a precise crystal and the other is a coarse internal ring. Each oscillator reaches the block as a single-cycle tick pulse sampled on the fabric clock. The block divides the chosen tick stream by a selectable ratio. Four ticks per machine cycle gives full speed, and 64 or 1024 ticks per machine cycle gives the low-power rates.

Software steers the controller through a few control inputs:
- a source request;
- an amplifier-off request for the crystal;
- a ratio code.

The block keeps the sequencing safe. The crystal amplifier may only be stopped while the core runs from the ring. A restarted crystal must count a programmable number of its own ticks before it is reported ready. A return to the crystal waits for that ready flag.

Any pending enabled interrupt or serial-port activity forces the block back to full speed without software help. The forced state holds until software itself selects the full-speed code. Every change of ratio or source is applied only at a machine-cycle boundary, so no cycle is ever shortened.

Top module: `pmc_clkctl`

## Requirements
- R1: After reset the block is in this state: `cyc_en`=0, `on_ring`=0, `xtal_running`=1, `xtal_ready`=1, `div_active`=00 and `hw_exited`=0.
- R2: The ratio code `div_sel` is decoded as follows: 00 gives 4 source ticks per machine cycle, 01 gives 64, 10 gives 1024, and 11 gives 4. `cyc_en` is a one-clock pulse after the last tick of each cycle and is never high in two consecutive clocks.
- R3: A new ratio or source is loaded only at a cycle boundary. `div_active` shows the loaded code (00, 01 or 10) and changes only in a clock where `cyc_en` is high.
- R4: With `sel_xtal`=0 the block moves to the ring at the next boundary. `on_ring` then reads 1 and ring ticks are counted with the same ratios.
- R5: `xtal_off_req`=1 stops the crystal amplifier (`xtal_running` goes to 0) only while `on_ring`=1 and `sel_xtal`=0. In any other state the request is ignored.
- R6: Stopping the amplifier clears `xtal_ready` in the same clock. Crystal ticks have no effect while the amplifier is stopped.
- R7: After the amplifier restarts (`xtal_off_req`=0), `xtal_ready` rises on the crystal tick that brings the warm-up count to `warmup_len`. A value of 0 is treated as 1.
- R8: The block returns to the crystal at a boundary only when `sel_xtal`=1 and `xtal_ready`=1. Until then it stays on the ring.
- R9: A hardware exit starts when `irq_pending` or `serial_active` is seen while `div_sel` decodes to 64 or 1024. Its effects are:
  - `hw_exited` is set on the next clock;
  - the ratio 4 is loaded at the next boundary and kept for as long as `hw_exited` is 1;
  - `hw_exited` clears once `div_sel` decodes to 4.
- R10: A wake event in the very clock of a boundary makes that boundary load ratio 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | One pulse per crystal oscillator period |
| ring_tick | input | 1 | One pulse per ring oscillator period |
| sel_xtal | input | 1 | 1 requests the crystal, 0 requests the ring |
| xtal_off_req | input | 1 | Request to stop the crystal amplifier |
| div_sel | input | 2 | Ratio code (00 /4, 01 /64, 10 /1024, 11 /4) |
| irq_pending | input | 1 | An enabled interrupt is pending |
| serial_active | input | 1 | Serial-port activity seen |
| warmup_len | input | WU_W | Crystal ticks needed before ready |
| cyc_en | output | 1 | Machine-cycle enable pulse |
| on_ring | output | 1 | Core currently paced by the ring |
| xtal_running | output | 1 | Crystal amplifier running |
| xtal_ready | output | 1 | Crystal warmed up and usable |
| div_active | output | 2 | Ratio code currently loaded |
| hw_exited | output | 1 | Forced full speed after a wake event |

## Verification
A wake event and a cycle boundary can fall in the same clock. The boundary loads a ratio while the wake logic overrides it. To provoke this, the bench runs at ratio 64 and counts 64 clocks from one `cyc_en` pulse. It then raises `serial_active` for exactly the clock in which the next boundary is registered. The result is judged at the ports: `div_active` must read 00 in the same clock as the `cyc_en` pulse of that boundary, and the following cycle must measure 4 clocks.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    DIV_FAST = 2'b00,
    DIV_MID  = 2'b01,
    DIV_SLOW = 2'b10
  } div_e;

  function automatic div_e decode_div(input logic [1:0] code);
    case (code)
      2'b01:   return DIV_MID;
      2'b10:   return DIV_SLOW;
      default: return DIV_FAST;
    endcase
  endfunction

endpackage

// File: rtl/pmc_warmup.sv
module pmc_warmup #(
  parameter int WU_W = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xtal_tick,
  input  logic            off_req,
  input  logic            on_ring,
  input  logic            sel_xtal,
  input  logic [WU_W-1:0] warmup_len,
  output logic            amp_on,
  output logic            ready,
  output logic            gated_tick
);

  logic [WU_W-1:0] wcnt;
  logic [WU_W:0]   next_cnt;
  logic            turn_off;

  assign turn_off   = off_req && on_ring && !sel_xtal;
  assign next_cnt   = {1'b0, wcnt} + 1'b1;
  assign gated_tick = xtal_tick && amp_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_on <= 1'b1;
      ready  <= 1'b1;
      wcnt   <= '0;
    end else if (turn_off) begin
      amp_on <= 1'b0;
      ready  <= 1'b0;
      wcnt   <= '0;
    end else if (!amp_on) begin
      if (!off_req) begin
        amp_on <= 1'b1;
      end
      wcnt <= '0;
    end else if (!ready && xtal_tick) begin
      if (next_cnt >= {1'b0, warmup_len}) begin
        ready <= 1'b1;
        wcnt  <= '0;
      end else begin
        wcnt <= next_cnt[WU_W-1:0];
      end
    end
  end

endmodule

// File: rtl/pmc_mode.sv
module pmc_mode
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       boundary,
  input  logic       sel_xtal,
  input  logic       xtal_ready,
  input  logic [1:0] div_sel,
  input  logic       wake,
  output logic       on_ring,
  output div_e       ratio,
  output logic       hw_exited
);

  div_e req_div;
  div_e eff_div;

  assign req_div = decode_div(div_sel);
  assign eff_div = (hw_exited || wake) ? DIV_FAST : req_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_exited <= 1'b0;
    end else if (req_div == DIV_FAST) begin
      hw_exited <= 1'b0;
    end else if (wake) begin
      hw_exited <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_ring <= 1'b0;
      ratio   <= DIV_FAST;
    end else if (boundary) begin
      on_ring <= !(sel_xtal && xtal_ready);
      ratio   <= eff_div;
    end
  end

endmodule

// File: rtl/pmc_divider.sv
module pmc_divider
  import pmc_pkg::*;
#(
  parameter int DIV_FAST_N = 4,
  parameter int DIV_MID_N  = 64,
  parameter int DIV_SLOW_N = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic src_tick,
  input  div_e ratio,
  output logic boundary,
  output logic cyc_en
);

  localparam int CW = $clog2(DIV_SLOW_N);

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  always_comb begin
    case (ratio)
      DIV_MID:  term = CW'(DIV_MID_N - 1);
      DIV_SLOW: term = CW'(DIV_SLOW_N - 1);
      default:  term = CW'(DIV_FAST_N - 1);
    endcase
  end

  assign boundary = src_tick && (cnt >= term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cyc_en <= 1'b0;
    end else begin
      cyc_en <= boundary;
      if (boundary) begin
        cnt <= '0;
      end else if (src_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pmc_clkctl.sv
module pmc_clkctl
  import pmc_pkg::*;
#(
  parameter int WU_W       = 17,
  parameter int DIV_FAST_N = 4,
  parameter int DIV_MID_N  = 64,
  parameter int DIV_SLOW_N = 1024
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xtal_tick,
  input  logic            ring_tick,
  input  logic            sel_xtal,
  input  logic            xtal_off_req,
  input  logic [1:0]      div_sel,
  input  logic            irq_pending,
  input  logic            serial_active,
  input  logic [WU_W-1:0] warmup_len,
  output logic            cyc_en,
  output logic            on_ring,
  output logic            xtal_running,
  output logic            xtal_ready,
  output logic [1:0]      div_active,
  output logic            hw_exited
);

  logic xt_gated;
  logic src_tick;
  logic boundary;
  div_e ratio;

  pmc_warmup #(.WU_W(WU_W)) u_warm (
    .clk        (clk),
    .rst        (rst),
    .xtal_tick  (xtal_tick),
    .off_req    (xtal_off_req),
    .on_ring    (on_ring),
    .sel_xtal   (sel_xtal),
    .warmup_len (warmup_len),
    .amp_on     (xtal_running),
    .ready      (xtal_ready),
    .gated_tick (xt_gated)
  );

  assign src_tick = on_ring ? ring_tick : xt_gated;

  pmc_divider #(
    .DIV_FAST_N (DIV_FAST_N),
    .DIV_MID_N  (DIV_MID_N),
    .DIV_SLOW_N (DIV_SLOW_N)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .ratio    (ratio),
    .boundary (boundary),
    .cyc_en   (cyc_en)
  );

  pmc_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .sel_xtal   (sel_xtal),
    .xtal_ready (xtal_ready),
    .div_sel    (div_sel),
    .wake       (irq_pending || serial_active),
    .on_ring    (on_ring),
    .ratio      (ratio),
    .hw_exited  (hw_exited)
  );

  assign div_active = ratio;

endmodule

// File: rtl/pmc_clkctl_chk.sv
module pmc_clkctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_xtal,
  input logic       cyc_en,
  input logic       on_ring,
  input logic       xtal_running,
  input logic       xtal_ready,
  input logic [1:0] div_active,
  input logic       hw_exited
);

  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    cyc_en |=> !cyc_en);

  assert_ratio_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_active) |-> cyc_en);

  assert_off_only_on_ring_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(xtal_running) |-> ($past(on_ring) && !$past(sel_xtal)));

  assert_ready_drops_with_amp_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(xtal_ready) |-> !xtal_running);

  assert_crystal_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(on_ring) |-> xtal_ready);

  assert_forced_fast_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && $past(hw_exited)) |-> (div_active == 2'b00));

endmodule

bind pmc_clkctl pmc_clkctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .sel_xtal     (sel_xtal),
  .cyc_en       (cyc_en),
  .on_ring      (on_ring),
  .xtal_running (xtal_running),
  .xtal_ready   (xtal_ready),
  .div_active   (div_active),
  .hw_exited    (hw_exited)
);

// File: tb/sim_pmc_clkctl.sv
`timescale 1ns/1ps
module sim_pmc_clkctl;

  localparam int WU_W = 17;
  localparam int NV   = 5;
  localparam logic [1:0] T_SEL [NV] = '{2'b00, 2'b01, 2'b11, 2'b10, 2'b00};
  localparam int         T_LEN [NV] = '{4, 64, 4, 1024, 4};
  localparam logic [1:0] T_ACT [NV] = '{2'b00, 2'b01, 2'b00, 2'b10, 2'b00};

  logic clk = 1'b0;
  logic rst;
  logic xtal_tick, ring_tick, sel_xtal, xtal_off_req;
  logic [1:0] div_sel;
  logic irq_pending, serial_active;
  logic [WU_W-1:0] warmup_len;
  logic cyc_en, on_ring, xtal_running, xtal_ready, hw_exited;
  logic [1:0] div_active;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmc_clkctl #(.WU_W(WU_W)) u0 (
    .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .ring_tick(ring_tick),
    .sel_xtal(sel_xtal), .xtal_off_req(xtal_off_req), .div_sel(div_sel),
    .irq_pending(irq_pending), .serial_active(serial_active),
    .warmup_len(warmup_len), .cyc_en(cyc_en), .on_ring(on_ring),
    .xtal_running(xtal_running), .xtal_ready(xtal_ready),
    .div_active(div_active), .hw_exited(hw_exited)
  );

  // ring oscillator model: one tick every third fabric clock
  initial begin
    int ph = 0;
    ring_tick = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      ring_tick = (ph == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cyc_en && n < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; xtal_tick = 1'b1; sel_xtal = 1'b1; xtal_off_req = 1'b0;
    div_sel = 2'b00; irq_pending = 1'b0; serial_active = 1'b0;
    warmup_len = WU_W'(5);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cyc_en && !on_ring && xtal_running && xtal_ready && div_active == 2'b00 && !hw_exited,
        "R1", {cyc_en, on_ring, xtal_running, xtal_ready, div_active, hw_exited}, 7'b0011000);
    rst = 1'b0;

    // R2/R3 ratio table walked on the crystal
    for (int i = 0; i < NV; i++) begin
      div_sel = T_SEL[i];
      wait_pulse(n); wait_pulse(n); wait_pulse(n);
      chk(n == T_LEN[i], "R2", n, T_LEN[i]);
      chk(div_active == T_ACT[i], "R3", div_active, T_ACT[i]);
    end

    // R5 off request ignored while on crystal
    xtal_off_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(xtal_running && xtal_ready, "R5", xtal_running, 1);
    xtal_off_req = 1'b0;

    // R4 move to ring
    sel_xtal = 1'b0;
    wait_pulse(n); wait_pulse(n);
    chk(on_ring == 1'b1, "R4", on_ring, 1);
    wait_pulse(n);
    chk(n == 12, "R4", n, 12);

    // R6 amplifier stop clears ready
    xtal_off_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(!xtal_running && !xtal_ready, "R6", {xtal_running, xtal_ready}, 0);

    // R8 crystal requested but not ready: stay on ring
    sel_xtal = 1'b1;
    wait_pulse(n); wait_pulse(n); wait_pulse(n);
    chk(on_ring == 1'b1, "R8", on_ring, 1);
    chk(!xtal_ready, "R6", xtal_ready, 0);

    // R7 warm-up of 5 crystal ticks
    xtal_off_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!xtal_ready, "R7", xtal_ready, 0);
    repeat (5) @(negedge clk);
    chk(xtal_ready, "R7", xtal_ready, 1);

    // R8 return to crystal once ready
    wait_pulse(n); wait_pulse(n);
    chk(on_ring == 1'b0, "R8", on_ring, 0);
    wait_pulse(n);
    chk(n == 4, "R8", n, 4);

    // R9 hardware exit from /1024
    div_sel = 2'b10;
    wait_pulse(n); wait_pulse(n);
    irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    chk(hw_exited, "R9", hw_exited, 1);
    wait_pulse(n);
    chk(div_active == 2'b00, "R9", div_active, 0);
    wait_pulse(n);
    chk(n == 4, "R9", n, 4);
    wait_pulse(n); wait_pulse(n);
    chk(hw_exited && div_active == 2'b00, "R9", div_active, 0);
    div_sel = 2'b00;
    @(negedge clk);
    chk(!hw_exited, "R9", hw_exited, 0);

    // R10 wake event in the boundary clock
    div_sel = 2'b01;
    wait_pulse(n); wait_pulse(n); wait_pulse(n);
    chk(n == 64 && div_active == 2'b01, "R10", n, 64);
    repeat (63) @(negedge clk);
    serial_active = 1'b1;
    @(negedge clk);
    serial_active = 1'b0;
    chk(cyc_en && div_active == 2'b00, "R10", div_active, 0);
    wait_pulse(n);
    chk(n == 4, "R10", n, 4);
    div_sel = 2'b00;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule